// File: doc/BRIEF.md
# Out-of-Order Instruction Issue Window

This block decouples instruction decode from execution. Decode writes each decoded instruction into one of a fixed number of window slots. The instruction carries an optional destination register, up to two optional source registers and the class of functional unit it needs. Decode keeps writing for as long as a slot is open. Every cycle the window looks at each functional unit that is idle and picks at most one waiting instruction for it. That instruction must need that unit and must be free of any hazard, so a blocked old instruction does not hold back younger independent ones.

Hazards are found by comparing register numbers only. An instruction is held while any of the following is true: a source is still to be produced by an older waiting instruction or by an instruction that is executing; its destination is still to be written by an older or executing instruction; its destination is still to be read by an older waiting instruction. Each unit runs one instruction at a time. The unit stays busy from the cycle its issue is taken until that unit returns a completion pulse. While busy, the unit's destination counts as pending in a scoreboard. When several instructions are ready for the same unit, the one that is oldest in program order is issued. Age is judged from a wrapping sequence tag given to each instruction as it enters.

Top module: `iw_issue_window`

## Requirements
- R1: While reset is low and in the first cycle after it is released, the window holds no entries, `win_full` is low, every unit is idle and no `issue_valid` bit is set.
- R2: An instruction presented with `in_valid` while `win_full` is low takes a slot and receives the next sequence tag. An instruction presented while `win_full` is high is dropped: it never issues and consumes no tag.
- R3: `win_full` is high exactly when all slots are occupied and none of them issues in the current cycle. In a cycle where a full window issues an entry, `win_full` is already low.
- R4: Unit class codes are 0 for integer, 1 for load/store and 2 for floating-point, and bit k of `issue_valid` belongs to class k. A hazard-free entry written at one clock edge shows `issue_valid` for its idle unit in the following cycle, with its destination and tag on that unit's output fields. The slot is freed and the unit turns busy at the next edge.
- R5: A younger entry issues to its idle unit while an older entry is still waiting.
- R6: Among ready entries for the same unit, only the oldest is issued. The tag is the 4-bit count of accepted instructions modulo 16, and age is judged across the wrap from 15 to 0.
- R7: Read-after-write: an entry is held while either of its valid sources equals the valid destination of an older unissued entry, or of an instruction executing on a busy unit.
- R8: Write-after-write: an entry is held while its valid destination equals the valid destination of an older unissued entry or of an executing instruction.
- R9: Write-after-read: an entry is held while its valid destination equals a valid source of an older unissued entry. The hold ends once that entry has issued.
- R10: Different units each issue one entry in the same cycle when each has a ready entry.
- R11: A `done` pulse for a busy unit makes it idle and clears its destination from the scoreboard. Entries waiting on either of these can issue in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Decoded instruction presented |
| in_dst_vld | input | 1 | Instruction writes a destination |
| in_dst | input | AREG_W | Destination register number |
| in_src0_vld | input | 1 | First source is used |
| in_src0 | input | AREG_W | First source register number |
| in_src1_vld | input | 1 | Second source is used |
| in_src1 | input | AREG_W | Second source register number |
| in_unit | input | UNIT_W | Required unit class |
| win_full | output | 1 | No slot can accept an instruction this cycle |
| done | input | NUM_UNITS | Completion pulse per unit |
| issue_valid | output | NUM_UNITS | An entry is issued to the unit this cycle |
| issue_dst_vld | output | NUM_UNITS | Issued entry writes a destination |
| issue_dst | output | NUM_UNITS*AREG_W | Destination of the issued entry, per unit |
| issue_tag | output | NUM_UNITS*SEQ_W | Sequence tag of the issued entry, per unit |

## Verification
The bench builds the window with its defaults: eight slots, three unit classes and 5-bit register numbers, which gives 4-bit tags. With eight slots the bench can fill the window in a few dozen cycles while the integer unit is held busy. That lets it check the full boundary, the dropping of an instruction offered to a full window, and the drop of the full flag in the cycle a slot issues. More than sixteen instructions enter over the run, so the window holds tags 13, 14, 15, 0 … 4 at once and the oldest-first choice is checked across the wrap. With three unit classes the bench can release three held units in one cycle and watch them issue together.

// File: rtl/iw_pkg.sv
// Package: shared definitions for the issue window.
// Assumes sequence tags are at most 8 bits wide.
package iw_pkg;

    typedef enum logic [1:0] {
        UC_INT = 2'd0,
        UC_MEM = 2'd1,
        UC_FLT = 2'd2
    } unit_class_e;

    // True when tag a was handed out before tag b. Both are w-bit wrapping
    // tags, and fewer than 2**(w-1) tags are live at once.
    function automatic logic seq_older(input logic [7:0] a, input logic [7:0] b,
                                       input int w);
        logic [7:0] diff;
        diff = (b - a) & ((8'd1 << w) - 8'd1);
        return (diff != 8'd0) && !diff[w-1];
    endfunction

endpackage

// File: rtl/iw_unit_track.sv
// Module: per-unit busy tracking and the register scoreboard.
// A unit turns busy on the edge that takes an issue and turns idle on its done
// pulse. Its destination counts as pending while it is busy.
// Assumes no issue is offered to a unit that is already busy.
module iw_unit_track #(
    parameter int NUM_UNITS = 3,
    parameter int AREG_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_UNITS-1:0]          issue_valid,
    input  logic [NUM_UNITS-1:0]          issue_dst_vld,
    input  logic [NUM_UNITS*AREG_W-1:0]   issue_dst,
    input  logic [NUM_UNITS-1:0]          done,
    output logic [NUM_UNITS-1:0]          unit_busy,
    output logic [(1<<AREG_W)-1:0]        reg_busy
);
    localparam int NUM_REGS = 1 << AREG_W;

    logic [NUM_UNITS-1:0]        run_dv;
    logic [NUM_UNITS*AREG_W-1:0] run_dst;

    // Record the in-flight instruction of each unit until it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_busy <= '0;
            run_dv    <= '0;
            run_dst   <= '0;
        end else begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (issue_valid[u]) begin
                    unit_busy[u]                  <= 1'b1;
                    run_dv[u]                     <= issue_dst_vld[u];
                    run_dst[u*AREG_W +: AREG_W]   <= issue_dst[u*AREG_W +: AREG_W];
                end else if (done[u]) begin
                    unit_busy[u] <= 1'b0;
                    run_dv[u]    <= 1'b0;
                end
            end
        end
    end

    // Mark each register that an executing instruction will still write.
    always_comb begin
        reg_busy = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (unit_busy[u] && run_dv[u])
                reg_busy[run_dst[u*AREG_W +: AREG_W]] = 1'b1;
        end
    end

    logic unused_regs;
    assign unused_regs = (NUM_REGS == 0);

endmodule

// File: rtl/iw_hazard.sv
// Module: hazard detection per window slot.
// Each slot is compared against every older occupied slot and against the
// scoreboard, covering read-after-write, write-after-write and
// write-after-read. A slot that has issued has read its operands.
module iw_hazard #(
    parameter int DEPTH  = 8,
    parameter int AREG_W = 5,
    parameter int SEQ_W  = 4
) (
    input  logic [DEPTH-1:0]          slot_vld,
    input  logic [DEPTH-1:0]          slot_dv,
    input  logic [DEPTH*AREG_W-1:0]   slot_dst,
    input  logic [DEPTH-1:0]          slot_s0v,
    input  logic [DEPTH*AREG_W-1:0]   slot_s0,
    input  logic [DEPTH-1:0]          slot_s1v,
    input  logic [DEPTH*AREG_W-1:0]   slot_s1,
    input  logic [DEPTH*SEQ_W-1:0]    slot_seq,
    input  logic [(1<<AREG_W)-1:0]    reg_busy,
    output logic [DEPTH-1:0]          blocked
);
    import iw_pkg::*;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [AREG_W-1:0] my_dst, my_s0, my_s1;
        assign my_dst = slot_dst[i*AREG_W +: AREG_W];
        assign my_s0  = slot_s0[i*AREG_W +: AREG_W];
        assign my_s1  = slot_s1[i*AREG_W +: AREG_W];

        // Gather the hazards of slot i against older slots and executing work.
        always_comb begin
            logic raw, waw, war;
            logic [AREG_W-1:0] o_dst, o_s0, o_s1;
            raw = (slot_s0v[i] && reg_busy[my_s0]) || (slot_s1v[i] && reg_busy[my_s1]);
            waw = slot_dv[i] && reg_busy[my_dst];
            war = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                o_dst = slot_dst[j*AREG_W +: AREG_W];
                o_s0  = slot_s0[j*AREG_W +: AREG_W];
                o_s1  = slot_s1[j*AREG_W +: AREG_W];
                if (slot_vld[j] && seq_older(8'(slot_seq[j*SEQ_W +: SEQ_W]),
                                             8'(slot_seq[i*SEQ_W +: SEQ_W]), SEQ_W)) begin
                    if (slot_dv[j] && slot_s0v[i] && o_dst == my_s0) raw = 1'b1;
                    if (slot_dv[j] && slot_s1v[i] && o_dst == my_s1) raw = 1'b1;
                    if (slot_dv[i] && slot_dv[j] && o_dst == my_dst) waw = 1'b1;
                    if (slot_dv[i] && slot_s0v[j] && o_s0 == my_dst) war = 1'b1;
                    if (slot_dv[i] && slot_s1v[j] && o_s1 == my_dst) war = 1'b1;
                end
            end
            blocked[i] = raw || waw || war;
        end
    end

endmodule

// File: rtl/iw_select.sv
// Module: per-unit oldest-first selection.
// A slot is a candidate when it is occupied, free of hazards and its unit is
// idle. Per unit the oldest candidate wins. A class code of NUM_UNITS or more
// never issues.
module iw_select #(
    parameter int DEPTH     = 8,
    parameter int NUM_UNITS = 3,
    parameter int UNIT_W    = 2,
    parameter int SEQ_W     = 4
) (
    input  logic [DEPTH-1:0]          slot_vld,
    input  logic [DEPTH-1:0]          blocked,
    input  logic [DEPTH*UNIT_W-1:0]   slot_unit,
    input  logic [DEPTH*SEQ_W-1:0]    slot_seq,
    input  logic [NUM_UNITS-1:0]      unit_busy,
    output logic [DEPTH-1:0]          slot_go,
    output logic [NUM_UNITS-1:0]      issue_valid
);
    import iw_pkg::*;

    logic [DEPTH-1:0] cand;

    // Find slots that could issue if no older slot competed for their unit.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cand[i] = 1'b0;
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (slot_vld[i] && !blocked[i] && !unit_busy[u] &&
                    slot_unit[i*UNIT_W +: UNIT_W] == UNIT_W'(u))
                    cand[i] = 1'b1;
            end
        end
    end

    // Keep the oldest candidate of each unit.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_go[i] = cand[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (cand[j] &&
                    slot_unit[j*UNIT_W +: UNIT_W] == slot_unit[i*UNIT_W +: UNIT_W] &&
                    seq_older(8'(slot_seq[j*SEQ_W +: SEQ_W]),
                              8'(slot_seq[i*SEQ_W +: SEQ_W]), SEQ_W))
                    slot_go[i] = 1'b0;
            end
        end
    end

    // Raise the handshake of every unit that received a winner.
    always_comb begin
        issue_valid = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (slot_go[i] && slot_unit[i*UNIT_W +: UNIT_W] == UNIT_W'(u))
                    issue_valid[u] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/iw_issue_window.sv
// Module: out-of-order issue window (top).
// Holds decoded instructions in DEPTH slots and writes each one into the
// lowest open slot. Every idle unit receives its oldest hazard-free waiting
// entry. A slot issuing this cycle counts as open for a write at the same edge.
// Assumes each unit runs one instruction at a time and signals done once.
module iw_issue_window #(
    parameter int DEPTH     = 8,
    parameter int NUM_UNITS = 3,
    parameter int AREG_W    = 5,
    parameter int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    parameter int SEQ_W     = $clog2(DEPTH) + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_dst_vld,
    input  logic [AREG_W-1:0]             in_dst,
    input  logic                          in_src0_vld,
    input  logic [AREG_W-1:0]             in_src0,
    input  logic                          in_src1_vld,
    input  logic [AREG_W-1:0]             in_src1,
    input  logic [UNIT_W-1:0]             in_unit,
    output logic                          win_full,
    input  logic [NUM_UNITS-1:0]          done,
    output logic [NUM_UNITS-1:0]          issue_valid,
    output logic [NUM_UNITS-1:0]          issue_dst_vld,
    output logic [NUM_UNITS*AREG_W-1:0]   issue_dst,
    output logic [NUM_UNITS*SEQ_W-1:0]    issue_tag
);
    localparam int NUM_REGS = 1 << AREG_W;

    logic [DEPTH-1:0]          slot_vld, slot_dv, slot_s0v, slot_s1v;
    logic [DEPTH*AREG_W-1:0]   slot_dst, slot_s0, slot_s1;
    logic [DEPTH*UNIT_W-1:0]   slot_unit;
    logic [DEPTH*SEQ_W-1:0]    slot_seq;
    logic [DEPTH-1:0]          slot_go, blocked, open_slot, alloc_oh;
    logic [SEQ_W-1:0]          next_seq;
    logic [NUM_UNITS-1:0]      unit_busy;
    logic [NUM_REGS-1:0]       reg_busy;
    logic                      accept;

    assign open_slot = ~slot_vld | slot_go;
    assign win_full  = ~|open_slot;
    assign accept    = in_valid && !win_full;

    // Pick the lowest-numbered open slot for the incoming instruction.
    always_comb begin
        logic found;
        found    = 1'b0;
        alloc_oh = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (open_slot[i] && !found) begin
                alloc_oh[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    // Hand out one sequence tag per accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) next_seq <= '0;
        else if (accept) next_seq <= next_seq + 1'b1;
    end

    // Fill slots on accept and release them on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld  <= '0;
            slot_dv   <= '0;
            slot_s0v  <= '0;
            slot_s1v  <= '0;
            slot_dst  <= '0;
            slot_s0   <= '0;
            slot_s1   <= '0;
            slot_unit <= '0;
            slot_seq  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (accept && alloc_oh[i]) begin
                    slot_vld[i]                  <= 1'b1;
                    slot_dv[i]                   <= in_dst_vld;
                    slot_s0v[i]                  <= in_src0_vld;
                    slot_s1v[i]                  <= in_src1_vld;
                    slot_dst[i*AREG_W +: AREG_W] <= in_dst;
                    slot_s0[i*AREG_W +: AREG_W]  <= in_src0;
                    slot_s1[i*AREG_W +: AREG_W]  <= in_src1;
                    slot_unit[i*UNIT_W +: UNIT_W] <= in_unit;
                    slot_seq[i*SEQ_W +: SEQ_W]   <= next_seq;
                end else if (slot_go[i]) begin
                    slot_vld[i] <= 1'b0;
                end
            end
        end
    end

    iw_hazard #(
        .DEPTH (DEPTH),
        .AREG_W(AREG_W),
        .SEQ_W (SEQ_W)
    ) u_hazard (
        .slot_vld(slot_vld),
        .slot_dv (slot_dv),
        .slot_dst(slot_dst),
        .slot_s0v(slot_s0v),
        .slot_s0 (slot_s0),
        .slot_s1v(slot_s1v),
        .slot_s1 (slot_s1),
        .slot_seq(slot_seq),
        .reg_busy(reg_busy),
        .blocked (blocked)
    );

    iw_select #(
        .DEPTH    (DEPTH),
        .NUM_UNITS(NUM_UNITS),
        .UNIT_W   (UNIT_W),
        .SEQ_W    (SEQ_W)
    ) u_select (
        .slot_vld   (slot_vld),
        .blocked    (blocked),
        .slot_unit  (slot_unit),
        .slot_seq   (slot_seq),
        .unit_busy  (unit_busy),
        .slot_go    (slot_go),
        .issue_valid(issue_valid)
    );

    // Route each winner's destination and tag onto its unit's output fields.
    always_comb begin
        issue_dst_vld = '0;
        issue_dst     = '0;
        issue_tag     = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (slot_go[i] && slot_unit[i*UNIT_W +: UNIT_W] == UNIT_W'(u)) begin
                    issue_dst_vld[u]             = slot_dv[i];
                    issue_dst[u*AREG_W +: AREG_W] = slot_dst[i*AREG_W +: AREG_W];
                    issue_tag[u*SEQ_W +: SEQ_W]   = slot_seq[i*SEQ_W +: SEQ_W];
                end
            end
        end
    end

    iw_unit_track #(
        .NUM_UNITS(NUM_UNITS),
        .AREG_W   (AREG_W)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid  (issue_valid),
        .issue_dst_vld(issue_dst_vld),
        .issue_dst    (issue_dst),
        .done         (done),
        .unit_busy    (unit_busy),
        .reg_busy     (reg_busy)
    );

endmodule

// File: rtl/iw_issue_window_chk.sv
// Module: assertion checker, bound to the issue window.
// Observes ports together with the slot occupancy and unit busy state.
module iw_issue_window_chk #(
    parameter int DEPTH     = 8,
    parameter int NUM_UNITS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 win_full,
    input logic [NUM_UNITS-1:0] issue_valid,
    input logic [NUM_UNITS-1:0] done,
    input logic [DEPTH-1:0]     slot_vld,
    input logic [NUM_UNITS-1:0] unit_busy
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (issue_valid == '0 && !win_full && slot_vld == '0)); // R1

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_full && in_valid) |=> ($countones(slot_vld) == $past($countones(slot_vld)))); // R2

    AST_FULL_ONLY_WHEN_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
        win_full |-> (slot_vld == '1 && issue_valid == '0)); // R3

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        AST_ISSUE_IDLE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[u] |-> !unit_busy[u]); // R4

        AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[u] |=> unit_busy[u]); // R4

        AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_busy[u] && done[u]) |=> !unit_busy[u]); // R11
    end

endmodule

bind iw_issue_window iw_issue_window_chk #(
    .DEPTH    (DEPTH),
    .NUM_UNITS(NUM_UNITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .win_full   (win_full),
    .issue_valid(issue_valid),
    .done       (done),
    .slot_vld   (slot_vld),
    .unit_busy  (unit_busy)
);

// File: tb/iw_issue_window_test.sv
`timescale 1ns/1ps
module iw_issue_window_test;
    import iw_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_dst_vld = 1'b0;
    logic [4:0]  in_dst = '0;
    logic        in_src0_vld = 1'b0;
    logic [4:0]  in_src0 = '0;
    logic        in_src1_vld = 1'b0;
    logic [4:0]  in_src1 = '0;
    logic [1:0]  in_unit = '0;
    logic        win_full;
    logic [2:0]  done = '0;
    logic [2:0]  issue_valid;
    logic [2:0]  issue_dst_vld;
    logic [14:0] issue_dst;
    logic [11:0] issue_tag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    iw_issue_window uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_dst_vld(in_dst_vld), .in_dst(in_dst),
        .in_src0_vld(in_src0_vld), .in_src0(in_src0),
        .in_src1_vld(in_src1_vld), .in_src1(in_src1),
        .in_unit(in_unit), .win_full(win_full), .done(done),
        .issue_valid(issue_valid), .issue_dst_vld(issue_dst_vld),
        .issue_dst(issue_dst), .issue_tag(issue_tag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_issue(input string req, input int vec, input int u, input int tag);
        chk(req, int'(issue_valid), vec);
        if (vec[u]) chk({req, " tag"}, int'(issue_tag[u*4 +: 4]), tag);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push(input int dst, input bit s0v, input int s0,
                        input bit s1v, input int s1, input unit_class_e u);
        in_valid = 1'b1; in_dst_vld = 1'b1; in_dst = 5'(dst);
        in_src0_vld = s0v; in_src0 = 5'(s0);
        in_src1_vld = s1v; in_src1 = 5'(s1);
        in_unit = u;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] m);
        done = m;
        @(negedge clk);
        done = '0;
    endtask

    task automatic t_reset();
        chk("R1 full", int'(win_full), 0);
        chk("R1 issue", int'(issue_valid), 0);
    endtask

    task automatic t_basic_raw();
        push(1, 0, 0, 0, 0, UC_INT);                    // tag 0
        chk_issue("R4 int issue", 3'b001, 0, 0);
        chk("R4 dst", int'(issue_dst[4:0]), 1);
        step();
        chk("R4 unit busy", int'(issue_valid), 0);
        push(2, 1, 1, 0, 0, UC_MEM);                    // tag 1 reads r1
        chk("R7 scoreboard raw", int'(issue_valid), 0);
        pulse(3'b001);
        chk_issue("R11 done releases", 3'b010, 1, 1);
        step();
        pulse(3'b010);
        chk("R11 idle", int'(issue_valid), 0);
    endtask

    task automatic t_ooo_oldest();
        push(5, 0, 0, 0, 0, UC_INT); step();            // tag 2 holds int
        push(6, 0, 0, 0, 0, UC_INT);                    // tag 3
        push(8, 0, 0, 0, 0, UC_INT);                    // tag 4
        push(7, 0, 0, 0, 0, UC_MEM);                    // tag 5
        chk_issue("R5 younger passes", 3'b010, 1, 5);
        step();
        pulse(3'b010);
        pulse(3'b001);
        chk_issue("R6 oldest wins", 3'b001, 0, 3);
        step();
        pulse(3'b001);
        chk_issue("R6 next oldest", 3'b001, 0, 4);
        step();
        pulse(3'b001);
        chk("R6 drained", int'(issue_valid), 0);
    endtask

    task automatic t_waw();
        push(20, 0, 0, 0, 0, UC_INT); step();           // tag 6
        push(10, 0, 0, 0, 0, UC_INT);                   // tag 7
        push(10, 0, 0, 0, 0, UC_MEM);                   // tag 8
        chk("R8 waw waiting", int'(issue_valid), 0);
        pulse(3'b001);
        chk_issue("R8 older first", 3'b001, 0, 7);
        step();
        chk("R8 waw executing", int'(issue_valid), 0);
        pulse(3'b001);
        chk_issue("R8 released", 3'b010, 1, 8);
        step();
        pulse(3'b010);
    endtask

    task automatic t_war();
        push(21, 0, 0, 0, 0, UC_INT); step();           // tag 9
        push(11, 1, 12, 0, 0, UC_INT);                  // tag 10 reads r12
        push(12, 0, 0, 0, 0, UC_MEM);                   // tag 11 writes r12
        chk("R9 war held", int'(issue_valid), 0);
        pulse(3'b001);
        chk_issue("R9 reader first", 3'b001, 0, 10);
        step();
        chk_issue("R9 released after read", 3'b010, 1, 11);
        step();
        pulse(3'b011);
    endtask

    task automatic t_full_wrap();
        push(23, 0, 0, 0, 0, UC_INT); step();           // tag 12
        for (int k = 0; k < 8; k++) begin               // tags 13..20
            push(k + 1, 0, 0, 0, 0, UC_INT);
            if (k == 6) chk("R3 seven not full", int'(win_full), 0);
        end
        chk("R3 full", int'(win_full), 1);
        push(30, 0, 0, 0, 0, UC_MEM);                   // dropped
        chk("R2 drop no issue", int'(issue_valid), 0);
        chk("R2 still full", int'(win_full), 1);
        pulse(3'b001);
        chk_issue("R6 oldest of full", 3'b001, 0, 13);
        chk("R3 full drops on issue", int'(win_full), 0);
        for (int k = 0; k < 7; k++) begin
            step();
            pulse(3'b001);
            chk_issue("R6 wrap order", 3'b001, 0, (14 + k) % 16);
        end
        step();
        pulse(3'b001);
        chk("R2 dropped never issues", int'(issue_valid), 0);
    endtask

    task automatic t_raw_waiting();
        push(22, 0, 0, 0, 0, UC_INT); step();           // tag 21
        push(13, 0, 0, 0, 0, UC_INT);                   // tag 22
        push(14, 0, 0, 1, 13, UC_MEM);                  // tag 23 reads r13
        chk("R7 raw waiting", int'(issue_valid), 0);
        pulse(3'b001);
        chk_issue("R7 producer first", 3'b001, 0, 6);
        step();
        chk("R7 raw executing", int'(issue_valid), 0);
        pulse(3'b001);
        chk_issue("R7 released", 3'b010, 1, 7);
        step();
        pulse(3'b010);
    endtask

    task automatic t_multi();
        push(24, 0, 0, 0, 0, UC_INT);                   // tags 24..26
        push(25, 0, 0, 0, 0, UC_MEM);
        push(26, 0, 0, 0, 0, UC_FLT);
        chk_issue("R4 fp issue", 3'b100, 2, 10);
        step();
        push(27, 0, 0, 0, 0, UC_INT);                   // tags 27..29
        push(28, 0, 0, 0, 0, UC_MEM);
        push(29, 0, 0, 0, 0, UC_FLT);
        chk("R10 all busy", int'(issue_valid), 0);
        pulse(3'b111);
        chk("R10 three at once", int'(issue_valid), 7);
        chk("R10 tag int", int'(issue_tag[3:0]), 11);
        chk("R10 tag mem", int'(issue_tag[7:4]), 12);
        chk("R10 tag fp", int'(issue_tag[11:8]), 13);
        step();
        pulse(3'b111);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic_raw();
        t_ooo_oldest();
        t_waw();
        t_war();
        t_full_wrap();
        t_raw_waiting();
        t_multi();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule